// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave end of a three-wire control link. It holds a bank of sixteen 12-bit configuration words. An external master reaches the bank over an active-low select, a direction line, a serial clock and one bidirectional data line. The data line is presented here as separate input, output and output-enable signals, so the pad stays outside the block. All four link inputs are treated as synchronous to the system clock `clk`. The block finds rising edges of the serial clock and of the direction line by comparing each input with its value one `clk` cycle earlier.

A write frame sends a 4-bit address and then a 12-bit data word. Both go least significant bit first, with the direction line low. The addressed word is updated only when the sixteenth bit arrives. A read frame sends the address with the direction line low. A rising edge on the direction line then copies the addressed word into the shift register, and the bits leave on the data line one per serial clock. If the select goes low while the direction line is already high, the current shift-register contents are shifted out without any address. Because a completed write also leaves its word in the shift register, this reads back the last word written.

Every word is also visible on a combinational parallel read port for the surrounding logic.

Top module: `cfg_serial_slave`

## Requirements
- R1: A synchronous active-high `rst` clears all sixteen words, the shift register and the bit counter to zero. After reset the parallel port reads zero and a serial read returns zero.
- R2: With `ser_sel_n` and `ser_dir` both low, each rising `ser_clk` samples `sdio_in`. The first four bits are address bits A0..A3 and the next twelve are data bits D0..D11, least significant bit first in both cases. After the sixteenth bit the addressed word holds the received data.
- R3: If `ser_sel_n` goes high before the sixteenth bit of a write frame, no word changes.
- R4: In a write frame, bits clocked after the sixteenth have no effect on any word.
- R5: `sdio_oe` is 1 exactly when `ser_sel_n` is low and `ser_dir` is high.
- R6: After at least four address bits, a rising `ser_dir` loads the addressed word into the shift register. `sdio_out` then presents D0, and each later rising `ser_clk` advances it by one bit, least significant bit first.
- R7: In a read frame, address bits after the fourth are ignored. Only the first four received select the word.
- R8: Once the twelve data bits have been shifted out, every further bit on `sdio_out` is 0.
- R9: A frame that starts with `ser_dir` already high shifts out the current shift-register contents. Right after a completed write, this is the word just written.
- R10: Raising `ser_sel_n` clears the bit counter, so the next frame starts again at address bit A0.
- R11: `par_data` always equals the word selected by `par_addr`, with no clock delay.
- R12: A rising `ser_dir` after fewer than four address bits loads nothing. The existing shift-register contents are shifted out instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Active-low frame select |
| ser_dir | input | 1 | Direction: 0 = master drives data, 1 = slave drives data |
| ser_clk | input | 1 | Serial bit clock; its rising edges are detected |
| sdio_in | input | 1 | Serial data from the master |
| sdio_out | output | 1 | Serial data to the master |
| sdio_oe | output | 1 | Drive enable for the data line |
| par_addr | input | 4 | Parallel read address |
| par_data | output | 12 | Parallel read data |

## Verification
The bench uses the default parameters: a 4-bit address and a 12-bit word. This gives the full bank of sixteen words, so addresses 0 and 15 and both extreme data patterns are written and read back over the serial link and the parallel port. A 12-bit word inside a 16-bit shift-out window lets four padding bits be observed after every read. The 4-bit address is short enough to test frames with too few address bits (two) and with extra ones (seven).

// File: rtl/csl_pkg.sv
package csl_pkg;
    // width of a counter that must hold values 0..n inclusive
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/csl_edge_det.sv
module csl_edge_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    typedef struct packed {
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.prev = sig;
    end

    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = sig[g] & ~st_q.prev[g];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/csl_regbank.sv
module csl_regbank #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    localparam int unsigned NUM_WORDS = 1 << ADDR_W;

    logic [NUM_WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];

    always_ff @(posedge clk) begin
        if (rst) mem_q <= '0;
        else     mem_q <= mem_d;
    end

    AST_WORD_COMMIT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R2
    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mem_q)); // R3
endmodule

// File: rtl/csl_frame_ctl.sv
module csl_frame_ctl #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              dir,
    input  logic              dir_rise,
    input  logic              clk_rise,
    input  logic              sdi,
    output logic              sdo,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);
    import csl_pkg::*;

    localparam int unsigned FRAME_LEN = ADDR_W + DATA_W;
    localparam int unsigned CNT_W     = cnt_width(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] shreg;
        logic              rd_frame;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_data = {sdi, st_q.shreg[DATA_W-1:1]};
        if (sel_n) begin
            // frame closed: counter and frame state return to idle
            st_d.cnt      = '0;
            st_d.addr     = '0;
            st_d.rd_frame = 1'b0;
        end else begin
            if (dir) st_d.rd_frame = 1'b1;
            if (dir_rise) begin
                if (st_q.cnt >= CNT_ADDR) st_d.shreg = rd_data;
            end else if (clk_rise) begin
                if (dir) begin
                    st_d.shreg = {1'b0, st_q.shreg[DATA_W-1:1]};
                end else begin
                    for (int i = 0; i < int'(ADDR_W); i++) begin
                        if (st_q.cnt == CNT_W'(i)) st_d.addr[i] = sdi;
                    end
                    if (!st_q.rd_frame && st_q.cnt >= CNT_ADDR && st_q.cnt < CNT_FULL) begin
                        st_d.shreg = wr_data;
                        wr_en      = (st_q.cnt == CNT_LAST);
                    end
                    if (st_q.cnt < CNT_FULL) st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    assign wr_addr = st_q.addr;
    assign rd_addr = st_q.addr;
    assign sdo     = st_q.shreg[0];

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> st_q.cnt == '0); // R10
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_FULL); // R4
    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> !wr_en); // R3
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && dir && !dir_rise && clk_rise) |=> st_q.shreg[DATA_W-1] == 1'b0); // R8
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_sel_n,
    input  logic              ser_dir,
    input  logic              ser_clk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic [ADDR_W-1:0] par_addr,
    output logic [DATA_W-1:0] par_data
);
    logic [1:0]        rise;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    csl_edge_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .sig  ({ser_dir, ser_clk}),
        .rise (rise)
    );

    csl_frame_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .sel_n    (ser_sel_n),
        .dir      (ser_dir),
        .dir_rise (rise[1]),
        .clk_rise (rise[0]),
        .sdi      (sdio_in),
        .sdo      (sdio_out),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    csl_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ra_addr (rd_addr),
        .ra_data (rd_data),
        .rb_addr (par_addr),
        .rb_data (par_data)
    );

    assign sdio_oe = ~ser_sel_n & ser_dir;

    AST_OE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        ser_sel_n |-> !sdio_oe); // R5
    AST_OE_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
        !ser_dir |-> !sdio_oe); // R5
endmodule

// File: tb/cfg_serial_slave_test.sv
module cfg_serial_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_sel_n = 1'b1;
    logic        ser_dir = 1'b0;
    logic        ser_clk = 1'b0;
    logic        sdio_in = 1'b0;
    logic        sdio_out, sdio_oe;
    logic [3:0]  par_addr = '0;
    logic [11:0] par_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    cfg_serial_slave uut (
        .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .ser_dir(ser_dir),
        .ser_clk(ser_clk), .sdio_in(sdio_in), .sdio_out(sdio_out),
        .sdio_oe(sdio_oe), .par_addr(par_addr), .par_data(par_data)
    );

    // {addr, data}
    localparam logic [15:0] VEC [6] = '{
        {4'h0, 12'hA5C}, {4'hF, 12'hFFF}, {4'h5, 12'h001},
        {4'hA, 12'h800}, {4'h3, 12'h3C7}, {4'h9, 12'h000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic pulse(input logic b);
        @(negedge clk) sdio_in = b; ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (2) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic open_frame(input logic d);
        @(negedge clk) ser_sel_n = 1'b0; ser_dir = d;
        @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk) ser_sel_n = 1'b1; ser_dir = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_bits(input logic [3:0] a, input logic [11:0] d, input int nbits, input logic extra);
        open_frame(1'b0);
        for (int i = 0; i < nbits; i++)
            pulse(i < 4 ? a[i] : (i < 16 ? d[i-4] : extra));
        close_frame();
    endtask

    // shift out 16 bits; if nab >= 0 clock nab address bits first, then raise dir
    task automatic read_bits(input logic [3:0] a, input int nab, output logic [15:0] q);
        if (nab < 0) begin
            open_frame(1'b1);
        end else begin
            open_frame(1'b0);
            for (int i = 0; i < nab; i++) pulse(i < 4 ? a[i] : ~a[i % 4]);
            @(negedge clk) ser_dir = 1'b1;
            repeat (2) @(negedge clk);
        end
        for (int i = 0; i < 16; i++) begin
            q[i] = sdio_out;
            pulse(1'b0);
        end
        close_frame();
    endtask

    task automatic par_read(input logic [3:0] a, output logic [11:0] d);
        @(negedge clk) par_addr = a;
        #1 d = par_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [15:0] q;
        logic [11:0] p;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        par_read(4'h0, p);  check("R1 par word0", {4'h0, p}, 16'h0);
        par_read(4'hF, p);  check("R1 par word15", {4'h0, p}, 16'h0);
        read_bits(4'h6, -1, q); check("R1 shreg zero", q, 16'h0);
        read_bits(4'h6, 4, q);  check("R1 serial read zero", q, 16'h0);
        check("R5 oe idle", {15'h0, sdio_oe}, 16'h0);

        // table: write all, then read each back
        foreach (VEC[k]) begin
            write_bits(VEC[k][15:12], VEC[k][11:0], 16, 1'b0);
            par_read(VEC[k][15:12], p);
            check("R2 R11 par after write", {4'h0, p}, {4'h0, VEC[k][11:0]});
        end
        foreach (VEC[k]) begin
            read_bits(VEC[k][15:12], 4, q);
            check("R6 R8 serial read", q, {4'h0, VEC[k][11:0]});
        end

        // R5: oe during frames
        open_frame(1'b0); #1 check("R5 oe write dir", {15'h0, sdio_oe}, 16'h0);
        @(negedge clk) ser_dir = 1'b1; #1 check("R5 oe read dir", {15'h0, sdio_oe}, 16'h1);
        @(negedge clk) ser_sel_n = 1'b1; #1 check("R5 oe deselected", {15'h0, sdio_oe}, 16'h0);
        close_frame();

        // R3: aborted write
        write_bits(4'h3, 12'h555, 10, 1'b0);
        par_read(4'h3, p); check("R3 abort keeps word", {4'h0, p}, 16'h03C7);
        // R10: fresh frame after abort starts at A0
        write_bits(4'h3, 12'h6B2, 16, 1'b0);
        par_read(4'h3, p); check("R10 write after abort", {4'h0, p}, 16'h06B2);

        // R9: readback of last written word
        read_bits(4'h0, -1, q); check("R9 readback", q, 16'h06B2);

        // R12: short address, existing contents shifted out
        write_bits(4'h7, 12'h1E4, 16, 1'b0);
        read_bits(4'h0, 2, q); check("R12 short address", q, 16'h01E4);

        // R4: bits beyond 16 ignored
        write_bits(4'hC, 12'h0F3, 20, 1'b1);
        par_read(4'hC, p); check("R4 word after long frame", {4'h0, p}, 16'h00F3);
        par_read(4'h0, p); check("R4 other word untouched", {4'h0, p}, 16'h0A5C);

        // R7: extra address bits ignored
        read_bits(4'hA, 7, q); check("R7 extra addr bits", q, 16'h0800);
        read_bits(4'h5, 6, q); check("R7 extra addr bits 2", q, 16'h0001);

        // R8: padding after all-ones word
        read_bits(4'hF, 4, q); check("R8 zero pad", {q[15:12], 12'h0}, 16'h0);

        report();
    end
endmodule